// File: doc/BRIEF.md
# Timer interrupt flag and enable controller

This block keeps the pending-event flags and the per-source enable bits for the interrupts of two timers. Three one-cycle event pulses arrive from the timers: a compare match A on timer 1, an overflow on timer 1 and an overflow on timer 0. Each pulse latches a sticky flag. A flag stays set until software writes a one to its bit, or until the core acknowledges the vector that belongs to it.

A flag raises a request only when three things are true: the flag is set, its enable bit is set, and the global interrupt enable input is high. The request output carries a fixed vector number. When several requests are pending together, the smallest vector number is presented. Software reaches the flag register and the enable register through a small byte-wide I/O port. The port has a combinational read path.

Top module: `tmr_irq_ctrl`

## Requirements
- R1: After reset, the flag register and the enable register both read 0x00, and `irq_req` is low.
- R2: An event pulse sets its flag on the next clock edge. In the flag register at I/O address 0x38, the timer 1 compare-A flag is bit 6, the timer 1 overflow flag is bit 2 and the timer 0 overflow flag is bit 1.
- R3: Bits 7, 5, 4, 3 and 0 of the flag register always read zero. Writing to those bits changes nothing.
- R4: The enable register sits at I/O address 0x39. Its bit 6 enables compare A on timer 1, bit 2 enables overflow on timer 1 and bit 1 enables overflow on timer 0. Its other bits read zero.
- R5: Writing a one to a flag bit clears that flag. Writing a zero to a flag bit leaves it unchanged.
- R6: An acknowledge (`irq_ack` high, with `ack_vec` carrying a vector number) clears only the flag whose vector matches. All other flags keep their value.
- R7: `irq_req` is high exactly when at least one source has its flag set, its enable bit set, and `gie` high.
- R8: The vector numbers are 3 for compare A on timer 1, 4 for overflow on timer 1 and 5 for overflow on timer 0. When several requests are pending, `irq_vec` shows the lowest vector number among them.
- R9: An event pulse in the same cycle as a write-one-to-clear or an acknowledge of the same flag leaves the flag set.
- R10: Addresses other than 0x38 and 0x39 read as 0x00, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gie | input | 1 | Global interrupt enable from the core |
| ev_cmpa1 | input | 1 | Timer 1 compare-A event pulse |
| ev_ovf1 | input | 1 | Timer 1 overflow event pulse |
| ev_ovf0 | input | 1 | Timer 0 overflow event pulse |
| io_addr | input | 6 | I/O address |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for `io_addr`, combinational |
| irq_ack | input | 1 | Core acknowledges a vector |
| ack_vec | input | 3 | Vector being acknowledged |
| irq_req | output | 1 | Interrupt request |
| irq_vec | output | 3 | Vector of the winning request |

## Verification
The main function is swept over every combination of the three flags, the three enable bits and the global enable. The sweep separates gating by the global enable from gating by each source's enable, and it shows that the lowest vector wins for every overlap of pending sources.

Directed patterns cover the rest:
- Single-bit and multi-bit write-one-to-clear, and zero writes, show that only the addressed flag bits are touched.
- Acknowledges of each vector in turn show that only the matching flag clears and that the next vector moves up.
- Events that coincide with a clear or an acknowledge show that setting takes precedence.
- Writes to reserved bits and to unmapped addresses show that they are ignored.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int NSRC   = 3;
  localparam int DATA_W = 8;
  localparam int VEC_W  = 3;

  typedef logic [VEC_W-1:0] vec_t;

  // Source index: 0 = timer 1 compare A, 1 = timer 1 overflow, 2 = timer 0 overflow.
  // Register bit position shared by the flag and enable registers.
  function automatic int src_bit(input int idx);
    case (idx)
      0:       return 6;
      1:       return 2;
      default: return 1;
    endcase
  endfunction

  // Fixed vector per source: the lower the index, the lower the vector.
  function automatic vec_t src_vec(input int idx);
    return vec_t'(3 + idx);
  endfunction

  // Mask of the implemented bits in either register.
  function automatic logic [DATA_W-1:0] live_bits();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < NSRC; i++) m[src_bit(i)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/tmr_irq_flag.sv
module tmr_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
    else if (clr_i)  q_o <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o); // R9
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o); // R5
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i) |=> $stable(q_o)); // R6
endmodule

// File: rtl/tmr_irq_arb.sv
module tmr_irq_arb
  import tmr_irq_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [N-1:0] pend_i,
  output logic         req_o,
  output vec_t         vec_o
);
  always_comb begin
    vec_o = '0;
    // Scan from the highest index down so that the lowest index wins.
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) vec_o = src_vec(i);
    end
  end

  assign req_o = |pend_i;

  always_comb begin
    if (pend_i[0]) AST_LOW_WINS: assert (vec_o == src_vec(0)); // R8
  end
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl
  import tmr_irq_pkg::*;
#(
  parameter int                ADDR_W    = 6,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 6'h38,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 6'h39
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gie,
  input  logic              ev_cmpa1,
  input  logic              ev_ovf1,
  input  logic              ev_ovf0,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic              irq_ack,
  input  logic [2:0]        ack_vec,
  output logic              irq_req,
  output logic [2:0]        irq_vec
);
  localparam logic [DATA_W-1:0] LIVE = live_bits();

  logic [NSRC-1:0] ev, flag_q, en_q, w1c, ack_hit, pend;
  logic            flag_wr, mask_wr;

  assign ev      = {ev_ovf0, ev_ovf1, ev_cmpa1};
  assign flag_wr = io_wr && (io_addr == FLAG_ADDR);
  assign mask_wr = io_wr && (io_addr == MASK_ADDR);

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign w1c[i]     = flag_wr && io_wdata[src_bit(i)];
    assign ack_hit[i] = irq_ack && (ack_vec == src_vec(i));

    tmr_irq_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (ev[i]),
      .clr_i (w1c[i] || ack_hit[i]),
      .q_o   (flag_q[i])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       en_q[i] <= 1'b0;
      else if (mask_wr) en_q[i] <= io_wdata[src_bit(i)];
    end

    assign pend[i] = flag_q[i] && en_q[i] && gie;
  end

  tmr_irq_arb #(.N(NSRC)) u_arb (
    .pend_i (pend),
    .req_o  (irq_req),
    .vec_o  (irq_vec)
  );

  always_comb begin
    io_rdata = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (io_addr == FLAG_ADDR)      io_rdata[src_bit(i)] = flag_q[i];
      else if (io_addr == MASK_ADDR) io_rdata[src_bit(i)] = en_q[i];
    end
  end

  always_comb begin
    AST_RSVD_ZERO: assert ((io_rdata & ~LIVE) == '0); // R3
  end

  AST_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (gie && (flag_q & en_q) != '0)); // R7
  AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec >= 3'd3 && irq_vec <= 3'd5)); // R8
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && ack_vec == 3'd3 && !ev_cmpa1) |=> !flag_q[0]); // R6
endmodule

// File: tb/tmr_irq_ctrl_bench.sv
`timescale 1ns/1ps
module tmr_irq_ctrl_bench;
  logic       clk = 0, rst_n = 0, gie = 0;
  logic       ev_cmpa1 = 0, ev_ovf1 = 0, ev_ovf0 = 0;
  logic [5:0] io_addr = 0;
  logic       io_wr = 0;
  logic [7:0] io_wdata = 0;
  logic [7:0] io_rdata;
  logic       irq_ack = 0;
  logic [2:0] ack_vec = 0;
  logic       irq_req;
  logic [2:0] irq_vec;
  int checks = 0, errors = 0;

  localparam logic [5:0] FA = 6'h38, MA = 6'h39;

  always #2.5 clk = ~clk;

  tmr_irq_ctrl u_tmr_irq_ctrl (.*);

  // Pattern bit 0 = cmpA1 (reg bit 6, vec 3), bit 1 = ovf1 (bit 2, vec 4), bit 2 = ovf0 (bit 1, vec 5)
  function automatic logic [7:0] to_reg(input logic [2:0] p);
    return {1'b0, p[0], 3'b000, p[1], p[2], 1'b0};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk); io_wr = 0;
  endtask

  task automatic pulse(input logic [2:0] p);
    @(negedge clk); {ev_ovf0, ev_ovf1, ev_cmpa1} = p;
    @(negedge clk); {ev_ovf0, ev_ovf1, ev_cmpa1} = 3'b000;
  endtask

  task automatic ack(input logic [2:0] v);
    @(negedge clk); irq_ack = 1; ack_vec = v;
    @(negedge clk); irq_ack = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    io_addr = a; #0.1; d = io_rdata;
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(FA, d); chk("R1 flag reset", d, 8'h00);
    rd(MA, d); chk("R1 mask reset", d, 8'h00);
    chk("R1 req reset", irq_req, 0);

    pulse(3'b111);
    rd(FA, d); chk("R2 all flags set", d, 8'h46);
    wr(FA, 8'hB9);
    rd(FA, d); chk("R3 reserved write ignored", d, 8'h46);
    wr(FA, 8'h04);
    rd(FA, d); chk("R5 w1c ovf1 only", d, 8'h42);
    wr(FA, 8'h00);
    rd(FA, d); chk("R5 zero write holds", d, 8'h42);
    wr(MA, 8'hFF);
    rd(MA, d); chk("R4 mask live bits", d, 8'h46);
    wr(6'h20, 8'hFF);
    rd(6'h20, d); chk("R10 unmapped reads zero", d, 8'h00);
    rd(FA, d); chk("R10 flags untouched", d, 8'h42);
    rd(MA, d); chk("R10 mask untouched", d, 8'h46);

    // R9: event with write-one-to-clear in the same cycle
    @(negedge clk); io_addr = FA; io_wdata = 8'h40; io_wr = 1; ev_cmpa1 = 1;
    @(negedge clk); io_wr = 0; ev_cmpa1 = 0;
    rd(FA, d); chk("R9 set beats w1c", d, 8'h42);
    // R9: event with acknowledge in the same cycle
    @(negedge clk); irq_ack = 1; ack_vec = 3'd3; ev_cmpa1 = 1;
    @(negedge clk); irq_ack = 0; ev_cmpa1 = 0;
    rd(FA, d); chk("R9 set beats ack", d, 8'h42);

    ack(3'd5);
    rd(FA, d); chk("R6 ack 5 clears ovf0 only", d, 8'h40);
    ack(3'd6);
    rd(FA, d); chk("R6 unmatched ack no effect", d, 8'h40);

    // R8: ordering through acknowledges
    pulse(3'b111); gie = 1;
    #0.1 chk("R8 first vec", irq_vec, 3); chk("R7 req on", irq_req, 1);
    ack(3'd3); #0.1 chk("R8 second vec", irq_vec, 4);
    ack(3'd4); #0.1 chk("R8 third vec", irq_vec, 5);
    ack(3'd5); #0.1 chk("R7 req off after acks", irq_req, 0);

    // Sweep over flags x enables x global enable: R2, R7, R8
    for (int p = 0; p < 8; p++)
      for (int m = 0; m < 8; m++)
        for (int g = 0; g < 2; g++) begin
          logic [2:0] act;
          logic [2:0] ev_v;
          wr(FA, 8'hFF);
          wr(MA, to_reg(3'(m)));
          gie = g[0];
          pulse(3'(p));
          rd(FA, d); chk("R2 sweep flags", d, to_reg(3'(p)));
          act = g[0] ? 3'(p & m) : 3'b000;
          chk("R7 sweep req", irq_req, act != 0);
          if (act != 0) begin
            ev_v = act[0] ? 3'd3 : (act[1] ? 3'd4 : 3'd5);
            chk("R8 sweep vec", irq_vec, ev_v);
          end
        end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule